// File: doc/BRIEF.md
# DRAM Frequency Switch Sequencer

This block carries out a memory clock change in hardware once software asks for one. Software first programs a control word. The word chooses the switch mode, the bypass path, whether the pads are held during the switch, and whether refresh timing is double-buffered. Software then raises the start bit. The sequencer waits until every bus master is either ready or excluded by a per-master mask. It then holds the pads if asked and requests the clock switch, and it waits for the clock logic to acknowledge. Next it moves the buffered refresh timing into the active copy in one step, releases the pads, and clears the start bit to report completion.

Refresh timing is double-buffered while the buffering bit is set. A write to the timing register then lands in a shadow copy and only takes effect at the switch. With buffering off, a timing write reaches the refresh outputs at once. Software polls the start bit. When it sees the bit clear, it writes zero to the control word to leave buffered mode.

The register port is a single-cycle write strobe with an address. Reads are combinational from the address. Addresses: 0 control, 1 timing (write; reads the active copy), 2 master mask, 3 shadow timing (read only).

Top module: `dfs_seq`

## Requirements
- R1: After reset the control word, active timing and mask read as zero, and `pad_hold` and `clk_sw_req` are low.
- R2: Writing the control word with bit 0 (start) set while idle launches a switch. Bit 0 reads back as 1 until the sequence ends and then clears by itself, with the other control bits kept.
- R3: `clk_sw_req` does not rise until, for every master i, mask bit i or `master_rdy[i]` is 1. A mask of all ones lets the switch proceed with no master ready.
- R4: When control bit 13 is set, `pad_hold` is high for the whole time `clk_sw_req` is high. When bit 13 is clear, `pad_hold` stays low throughout the switch.
- R5: Once raised, `clk_sw_req` stays high until a cycle in which `clk_sw_ack` is high.
- R6: With control bit 15 set, a timing write changes only the shadow copy. The refresh outputs keep their value until the switch copies the shadow into the active copy, after the acknowledge.
- R7: With control bit 15 clear, a timing write reaches the refresh outputs on the next cycle.
- R8: A control write while a switch is in progress is ignored: the control word reads back unchanged.
- R9: `sw_mode` follows control bit 1 (0 dynamic switch, 1 alternate clock mode), and `sw_bypass` follows control bit 4.
- R10: `rfsh_intv` comes from timing bits [31:16] (refresh interval in 32-clock units), and `rfsh_cyc` comes from bits [15:0] (refresh cycle time in clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| master_rdy | input | NUM_MASTERS | Per-master ready |
| clk_sw_req | output | 1 | Clock switch request |
| clk_sw_ack | input | 1 | Clock switch acknowledge |
| pad_hold | output | 1 | Pad hold during switch |
| sw_mode | output | 1 | Selected switch mode |
| sw_bypass | output | 1 | Bypass enable |
| rfsh_intv | output | 16 | Active refresh interval |
| rfsh_cyc | output | 16 | Active refresh cycle time |

## Verification
The assertions assume the clock logic gives `clk_sw_ack` only in answer to a pending request. The bench's responder keeps to this: it raises the acknowledge only while `clk_sw_req` is high and drops it as soon as the request falls. The assertions also assume that `master_rdy` may change at any time. The stimulus toggles it and changes the mask during a wait, and it uses a full mask with no ready master. All register writes take exactly one cycle, and the bench drives them between clock edges.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_HOLD, ST_SWITCH, ST_COPY, ST_RELEASE
  } seq_state_t;

  localparam int CTRL_START   = 0;
  localparam int CTRL_MODE    = 1;
  localparam int CTRL_BYPASS  = 4;
  localparam int CTRL_PADHOLD = 13;
  localparam int CTRL_BUFFER  = 15;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_A013;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_TIMING = 1;
  localparam int ADR_MASK   = 2;
  localparam int ADR_SHADOW = 3;
endpackage

// File: rtl/dfs_ready_gate.sv
module dfs_ready_gate #(
  parameter int NUM_MASTERS = 8
) (
  input  logic [NUM_MASTERS-1:0] mask,
  input  logic [NUM_MASTERS-1:0] rdy,
  output logic                   all_ok
);
  logic [NUM_MASTERS-1:0] ok;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_master
    assign ok[i] = mask[i] | rdy[i];
  end

  assign all_ok = &ok;
endmodule

// File: rtl/dfs_regs.sv
module dfs_regs
  import dfs_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int NUM_MASTERS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wdata,
  input  logic                   busy,
  input  logic                   copy_stb,
  input  logic                   done_stb,
  output logic [31:0]            ctrl_q,
  output logic [NUM_MASTERS-1:0] mask_q,
  output logic [31:0]            active_q,
  output logic [31:0]            rdata
);
  logic [31:0]            ctrl_d, shadow_q, shadow_d, active_d;
  logic [NUM_MASTERS-1:0] mask_d;
  logic wr_ctrl, wr_tim, wr_mask, buf_on;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(ADR_CTRL));
  assign wr_tim  = wr_en && (addr == ADDR_W'(ADR_TIMING));
  assign wr_mask = wr_en && (addr == ADDR_W'(ADR_MASK));
  assign buf_on  = ctrl_q[CTRL_BUFFER];

  always_comb begin
    ctrl_d = ctrl_q;
    if (done_stb)
      ctrl_d[CTRL_START] = 1'b0;
    else if (wr_ctrl && !busy)
      ctrl_d = wdata & CTRL_WMASK;
  end

  always_comb begin
    shadow_d = wr_tim ? wdata : shadow_q;
    active_d = active_q;
    if (copy_stb)
      active_d = shadow_q;
    else if (wr_tim && !buf_on)
      active_d = wdata;
  end

  assign mask_d = wr_mask ? wdata[NUM_MASTERS-1:0] : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      shadow_q <= '0;
      active_q <= '0;
      mask_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_d;
      shadow_q <= shadow_d;
      active_q <= active_d;
      mask_q   <= mask_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(ADR_CTRL):   rdata = ctrl_q;
      ADDR_W'(ADR_TIMING): rdata = active_q;
      ADDR_W'(ADR_MASK):   rdata = 32'(mask_q);
      ADDR_W'(ADR_SHADOW): rdata = shadow_q;
      default:             rdata = '0;
    endcase
  end

  // R2: start only falls at the end of a sequence
  a_r2_start_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q[CTRL_START]) |-> $past(done_stb));
  // R6: buffered timing held until the copy step
  a_r6_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_on && !copy_stb) |=> $stable(active_q));
  // R8: control locked during a switch
  a_r8_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && !done_stb) |=> $stable(ctrl_q));
endmodule

// File: rtl/dfs_fsm.sv
module dfs_fsm
  import dfs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic all_ok,
  input  logic pad_en,
  input  logic buf_en,
  input  logic clk_sw_ack,
  output logic busy,
  output logic copy_stb,
  output logic done_stb,
  output logic clk_sw_req,
  output logic pad_hold
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start) state_d = ST_WAIT;
      ST_WAIT:    if (all_ok) state_d = ST_HOLD;
      ST_HOLD:    state_d = ST_SWITCH;
      ST_SWITCH:  if (clk_sw_ack) state_d = ST_COPY;
      ST_COPY:    state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy       = (state_q != ST_IDLE);
  assign clk_sw_req = (state_q == ST_SWITCH);
  assign copy_stb   = (state_q == ST_COPY) && buf_en;
  assign done_stb   = (state_q == ST_RELEASE);
  assign pad_hold   = pad_en && ((state_q == ST_HOLD) || (state_q == ST_SWITCH)
                                 || (state_q == ST_COPY));

  // R3: request only after masters were cleared
  a_r3_ready_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sw_req) |-> $past(all_ok, 2));
  // R5: request held until acknowledged
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sw_req && !clk_sw_ack) |=> clk_sw_req);
  // R4: pad hold only when enabled, and over the whole request
  a_r4_hold_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    pad_hold |-> pad_en);
  a_r4_hold_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sw_req && pad_en) |-> pad_hold);
endmodule

// File: rtl/dfs_seq.sv
module dfs_seq
  import dfs_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int NUM_MASTERS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [NUM_MASTERS-1:0] master_rdy,
  output logic                   clk_sw_req,
  input  logic                   clk_sw_ack,
  output logic                   pad_hold,
  output logic                   sw_mode,
  output logic                   sw_bypass,
  output logic [15:0]            rfsh_intv,
  output logic [15:0]            rfsh_cyc
);
  logic [31:0]            ctrl_q, active_q;
  logic [NUM_MASTERS-1:0] mask_q;
  logic busy, copy_stb, done_stb, all_ok;

  dfs_regs #(.ADDR_W(ADDR_W), .NUM_MASTERS(NUM_MASTERS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .copy_stb(copy_stb),
    .done_stb(done_stb), .ctrl_q(ctrl_q), .mask_q(mask_q),
    .active_q(active_q), .rdata(reg_rdata)
  );

  dfs_ready_gate #(.NUM_MASTERS(NUM_MASTERS)) u_gate (
    .mask(mask_q), .rdy(master_rdy), .all_ok(all_ok)
  );

  dfs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(ctrl_q[CTRL_START]), .all_ok(all_ok),
    .pad_en(ctrl_q[CTRL_PADHOLD]), .buf_en(ctrl_q[CTRL_BUFFER]),
    .clk_sw_ack(clk_sw_ack), .busy(busy), .copy_stb(copy_stb),
    .done_stb(done_stb), .clk_sw_req(clk_sw_req), .pad_hold(pad_hold)
  );

  assign sw_mode   = ctrl_q[CTRL_MODE];
  assign sw_bypass = ctrl_q[CTRL_BYPASS];
  assign rfsh_intv = active_q[31:16];
  assign rfsh_cyc  = active_q[15:0];
endmodule

// File: tb/dfs_seq_test.sv
module dfs_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  master_rdy = '0;
  logic        clk_sw_req, clk_sw_ack = 1'b0, pad_hold, sw_mode, sw_bypass;
  logic [15:0] rfsh_intv, rfsh_cyc;

  int checks = 0, failures = 0;
  int ack_delay = 2, ack_cnt = 0;
  int req_run = 0, req_run_max = 0;
  bit pad_gap = 0, pad_seen = 0, done = 0;
  logic [31:0] exp_q[$];
  logic [31:0] last_out = '0;

  always #4 clk = ~clk;

  dfs_seq uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      rd(2'd0, v);
      if (!v[0]) begin ok = 1; break; end
    end
  endtask

  // clock switch acknowledge responder
  always @(negedge clk) begin
    if (clk_sw_req) begin
      if (ack_cnt == ack_delay) clk_sw_ack = 1'b1;
      else ack_cnt++;
    end else begin
      clk_sw_ack = 1'b0; ack_cnt = 0;
    end
  end

  // monitor: request run length, pad coverage, scoreboard of refresh outputs
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (clk_sw_req) begin
        req_run++;
        if (req_run > req_run_max) req_run_max = req_run;
        if (!pad_hold) pad_gap = 1;
      end else req_run = 0;
      if (pad_hold) pad_seen = 1;
      if ({rfsh_intv, rfsh_cyc} !== last_out) begin
        if (exp_q.size() == 0)
          chk(0, "R6/R7 unexpected refresh change", {rfsh_intv, rfsh_cyc}, last_out);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk({rfsh_intv, rfsh_cyc} === e, "R6/R7/R10 refresh outputs", {rfsh_intv, rfsh_cyc}, e);
        end
        last_out = {rfsh_intv, rfsh_cyc};
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(2'd0, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 timing reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 mask reset", v, 0);
    chk(!pad_hold && !clk_sw_req, "R1 outputs idle", {pad_hold, clk_sw_req}, 0);

    // R7 / R10: unbuffered write takes effect at once
    exp_q.push_back(32'h0012_0034);
    wr(2'd1, 32'h0012_0034);
    @(negedge clk); #3;
    chk(rfsh_intv == 16'h0012, "R10 interval field", rfsh_intv, 16'h0012);
    chk(rfsh_cyc == 16'h0034, "R7 immediate cycle field", rfsh_cyc, 16'h0034);

    // R9: mode and bypass, buffering and pad hold on
    wr(2'd0, 32'h0000_A012);
    #3;
    chk(sw_mode && sw_bypass, "R9 mode/bypass", {sw_mode, sw_bypass}, 2'b11);
    // R6: buffered write goes to shadow only
    wr(2'd1, 32'h0040_0055);
    repeat (3) @(negedge clk);
    #3;
    chk({rfsh_intv, rfsh_cyc} == 32'h0012_0034, "R6 active held", {rfsh_intv, rfsh_cyc}, 32'h0012_0034);
    rd(2'd3, v); chk(v == 32'h0040_0055, "R6 shadow written", v, 32'h0040_0055);

    // R3 / R2: stalled by unready unmasked masters
    exp_q.push_back(32'h0040_0055);
    pad_gap = 0;
    wr(2'd0, 32'h0000_A013);
    master_rdy = 8'h0A;
    repeat (10) @(negedge clk);
    chk(!clk_sw_req, "R3 stalled without ready", clk_sw_req, 0);
    rd(2'd0, v); chk(v[0], "R2 start reads busy", v, 32'h0000_A013);
    // R8: control write while busy ignored
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); chk(v == 32'h0000_A013, "R8 busy write ignored", v, 32'h0000_A013);
    master_rdy = 8'h0F;
    repeat (5) @(negedge clk);
    chk(!clk_sw_req, "R3 partial ready still stalls", clk_sw_req, 0);
    wr(2'd2, 32'h0000_00F0);
    wait_done(ok);
    chk(ok, "R2 start self-clears", ok, 1);
    rd(2'd0, v); chk(v == 32'h0000_A012, "R2 other bits kept", v, 32'h0000_A012);
    chk(!pad_gap && pad_seen, "R4 pad hold covers request", {pad_gap, pad_seen}, 2'b01);
    chk(!pad_hold, "R4 pad released", pad_hold, 0);

    // R5 / R3 / R4: full mask, no ready, no pad hold, no buffering
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h0000_00FF);
    master_rdy = 8'h00;
    ack_delay = 5; req_run_max = 0; pad_seen = 0;
    wr(2'd0, 32'h0000_0001);
    wait_done(ok);
    chk(ok, "R3 full mask proceeds", ok, 1);
    chk(req_run_max >= 6, "R5 request held until ack", req_run_max, 6);
    chk(!pad_seen, "R4 no pad hold when disabled", pad_seen, 0);
    #3;
    chk({rfsh_intv, rfsh_cyc} == 32'h0040_0055, "R6 unbuffered switch keeps timing",
        {rfsh_intv, rfsh_cyc}, 32'h0040_0055);

    // R7 again after buffering off
    exp_q.push_back(32'h0007_0009);
    wr(2'd1, 32'h0007_0009);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule